// File: doc/BRIEF.md
# Sleep-Capable Conversion Trigger Timer

This block paces conversions for an analog subsystem while the chip sleeps. A low-rate sleep clock is taken from one of two tick sources (the low-power oscillator or the medium-frequency clock) and divided by a power of two. A reload-style 16-bit down counter is then clocked from that divided tick, the peripheral clock tick or the low-frequency clock tick. Each time it expires, it pulses a trigger to any subset of up to four ADC sequencers.

The block also produces a request that keeps the local oscillator running. In always-on mode the request is held high. In duty-cycled mode it is raised only when the timer fires, and it is held for a programmable number of oscillator ticks. Every clock source is modelled as a one-cycle tick-enable input in the single system clock domain.

Configuration arrives over a plain write port: a strobe, a 2-bit address and a 16-bit data word. A write is accepted in the cycle its strobe is high, and the port has no back-pressure. The block carries no data stream, so all pins are plain control.

Top module: `lpt_trigger_timer`

## Requirements
- R1: Reset clears the control and period registers to 0, which disables the timer and the oscillator request. The oscillator hold register resets to 4. After reset, `adc_trig` and `osc_req` are 0.
- R2: A write with `cfg_wr_en` high updates one register at the rising edge: address 0 is control, address 1 is the period N (16 bits) and address 2 is the hold count (bits 7:0). Address 3 is ignored. Control bit fields are: bit 0 timer enable, bit 1 oscillator enable, bit 2 oscillator always-on, bit 3 sleep source, bits 6:4 divider code, bits 9:8 timer clock, bits 15:12 trigger mask.
- R3: A sleep source bit of 0 selects `lposc_tick` and 1 selects `mfclk_tick` as the sleep clock source.
- R4: Divider code 0 passes every source tick. Codes 1, 2, 3 and 4 pass one source tick in 2, 4, 8 and 16, and codes 5 to 7 also divide by 16. The divided tick falls on each source tick for which the low k bits of a count of source ticks since reset are all ones; that count then advances.
- R5: Timer clock code 0 selects `peri_tick`, 1 the divided sleep tick and 2 `lf_tick`. Code 3 gives no ticks.
- R6: In the cycle after the timer enable is first seen set, the counter loads N. Each selected tick decrements it. A tick that finds the counter at 0 fires and reloads N, so triggers come every N+1 ticks (N=0 fires on every tick). The trigger is a one-cycle pulse that appears in the cycle after the firing tick.
- R7: On a firing, `adc_trig` equals the 4-bit trigger mask. Bit i drives ADC sequencer i.
- R8: A period written while the timer runs leaves the current count alone and is used from the next reload.
- R9: Clearing the timer enable stops triggers and clears the counter. Setting it again reloads N.
- R10: With the oscillator enable set and always-on set, `osc_req` is 1.
- R11: With the oscillator enable set and always-on clear, a timer firing raises `osc_req` in the cycle the trigger appears. `osc_req` stays high until the hold count of `lposc_tick` pulses has passed; a firing restarts that count, and a hold of 0 raises nothing.
- R12: With the oscillator enable clear, `osc_req` is 0 and any duty-cycle hold in progress is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | 16 | Write data |
| lposc_tick | input | 1 | Low-power oscillator tick |
| mfclk_tick | input | 1 | Medium-frequency clock tick |
| peri_tick | input | 1 | Peripheral clock tick |
| lf_tick | input | 1 | Low-frequency clock tick |
| adc_trig | output | 4 | One-cycle trigger per ADC sequencer |
| osc_req | output | 1 | Oscillator run request |

## Verification
A divider phase that has slipped moves every later trigger by a whole divided period, so it shows at `adc_trig` within one timer interval. A counter that reloads wrongly or misses its reload shows as a wrong gap between trigger pulses, again within one interval. A hold count that is off shows at `osc_req` as a falling edge one or more oscillator ticks early or late after the next firing. A reference model advanced every cycle from the same inputs is therefore compared at both outputs in every cycle, so the first wrong cycle is the one reported.

// File: rtl/lpt_pkg.sv
package lpt_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_PERIOD = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_HOLD   = 2'd2;

  // control word field positions
  localparam int CTL_TMR_EN   = 0;
  localparam int CTL_OSC_EN   = 1;
  localparam int CTL_OSC_ALW  = 2;
  localparam int CTL_SLP_SRC  = 3;
  localparam int CTL_DIV_LSB  = 4;
  localparam int CTL_TCLK_LSB = 8;
  localparam int CTL_MASK_LSB = 12;
  localparam int DIV_CODE_W   = 3;

  typedef enum logic [1:0] {
    TCLK_PERI  = 2'd0,
    TCLK_SLEEP = 2'd1,
    TCLK_LF    = 2'd2,
    TCLK_NONE  = 2'd3
  } tclk_sel_e;
endpackage

// File: rtl/lpt_cfg_regs.sv
module lpt_cfg_regs
  import lpt_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int NUM_ADC      = 4,
  parameter int HOLD_W       = 8,
  parameter int HOLD_DEFAULT = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [CNT_W-1:0]      wdata_i,
  output logic                  tmr_en_o,
  output logic                  osc_en_o,
  output logic                  osc_alw_o,
  output logic                  slp_src_o,
  output logic [DIV_CODE_W-1:0] div_code_o,
  output tclk_sel_e             tclk_o,
  output logic [NUM_ADC-1:0]    trig_mask_o,
  output logic [CNT_W-1:0]      period_o,
  output logic [HOLD_W-1:0]     hold_o
);
  logic [CNT_W-1:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_o <= '0;
      hold_o   <= HOLD_W'(HOLD_DEFAULT);
    end else if (wr_en_i) begin
      case (addr_i)
        ADDR_CTRL:   ctrl_q   <= wdata_i;
        ADDR_PERIOD: period_o <= wdata_i;
        ADDR_HOLD:   hold_o   <= wdata_i[HOLD_W-1:0];
        default:     ;
      endcase
    end
  end

  assign tmr_en_o    = ctrl_q[CTL_TMR_EN];
  assign osc_en_o    = ctrl_q[CTL_OSC_EN];
  assign osc_alw_o   = ctrl_q[CTL_OSC_ALW];
  assign slp_src_o   = ctrl_q[CTL_SLP_SRC];
  assign div_code_o  = ctrl_q[CTL_DIV_LSB +: DIV_CODE_W];
  assign tclk_o      = tclk_sel_e'(ctrl_q[CTL_TCLK_LSB +: 2]);
  assign trig_mask_o = ctrl_q[CTL_MASK_LSB +: NUM_ADC];

  wire unused_ctrl = ^{ctrl_q[7], ctrl_q[11:10], wdata_i};
endmodule

// File: rtl/lpt_sleep_div.sv
module lpt_sleep_div
  import lpt_pkg::*;
#(
  parameter int DIV_LOG = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  lposc_tick_i,
  input  logic                  mfclk_tick_i,
  input  logic                  slp_src_i,
  input  logic [DIV_CODE_W-1:0] div_code_i,
  output logic                  dslp_tick_o
);
  logic               src_tick;
  logic [DIV_LOG-1:0] phase_q;
  logic [DIV_LOG-1:0] sel_mask;

  assign src_tick = slp_src_i ? mfclk_tick_i : lposc_tick_i;

  // code k selects the low k phase bits; codes past DIV_LOG saturate
  genvar gi;
  generate
    for (gi = 0; gi < DIV_LOG; gi++) begin : g_mask
      assign sel_mask[gi] = (int'(div_code_i) > gi);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)        phase_q <= '0;
    else if (src_tick) phase_q <= phase_q + 1'b1;
  end

  assign dslp_tick_o = src_tick && ((phase_q & sel_mask) == sel_mask);

  assert_div_no_back_to_back_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (div_code_i != '0 && $stable(div_code_i) && $past(dslp_tick_o)) |-> !dslp_tick_o);
endmodule

// File: rtl/lpt_down_timer.sv
module lpt_down_timer
  import lpt_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int NUM_ADC = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  tclk_sel_e          tclk_i,
  input  logic               peri_tick_i,
  input  logic               dslp_tick_i,
  input  logic               lf_tick_i,
  input  logic [CNT_W-1:0]   period_i,
  input  logic [NUM_ADC-1:0] mask_i,
  output logic               fire_o,
  output logic [NUM_ADC-1:0] trig_o
);
  logic             tick;
  logic             armed_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    case (tclk_i)
      TCLK_PERI:  tick = peri_tick_i;
      TCLK_SLEEP: tick = dslp_tick_i;
      TCLK_LF:    tick = lf_tick_i;
      default:    tick = 1'b0;
    endcase
  end

  assign fire_o = en_i && armed_q && tick && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n || !en_i) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (!armed_q) begin
      cnt_q   <= period_i;
      armed_q <= 1'b1;
    end else if (tick) begin
      cnt_q   <= (cnt_q == '0) ? period_i : cnt_q - 1'b1;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_ADC; gi++) begin : g_trig
      always_ff @(posedge clk) begin
        if (!rst_n) trig_o[gi] <= 1'b0;
        else        trig_o[gi] <= fire_o && mask_i[gi];
      end
    end
  endgenerate

  assert_no_trig_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_o) |-> $past(en_i));
  assert_trig_within_mask_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_o & ~$past(mask_i)) == '0);
  assert_reserved_clock_silent_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (|trig_o) |-> ($past(tclk_i) != TCLK_NONE));
endmodule

// File: rtl/lpt_osc_gate.sv
module lpt_osc_gate #(
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_en_i,
  input  logic              osc_alw_i,
  input  logic              fire_i,
  input  logic              lposc_tick_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              osc_req_o
);
  logic [HOLD_W-1:0] remain_q;
  logic              duty_active;

  always_ff @(posedge clk) begin
    if (!rst_n || !osc_en_i || osc_alw_i)    remain_q <= '0;
    else if (fire_i)                         remain_q <= hold_i;
    else if (lposc_tick_i && remain_q != '0) remain_q <= remain_q - 1'b1;
  end

  assign duty_active = (remain_q != '0);
  assign osc_req_o   = osc_en_i && (osc_alw_i || duty_active);

  assert_duty_rise_on_fire_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(duty_active) |-> $past(fire_i));
  assert_off_clears_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(osc_en_i) |-> !duty_active);
endmodule

// File: rtl/lpt_trigger_timer.sv
module lpt_trigger_timer
  import lpt_pkg::*;
#(
  parameter int CNT_W        = 16,
  parameter int NUM_ADC      = 4,
  parameter int HOLD_W       = 8,
  parameter int HOLD_DEFAULT = 4,
  parameter int DIV_LOG      = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_wr_en,
  input  logic [1:0]         cfg_addr,
  input  logic [CNT_W-1:0]   cfg_wdata,
  input  logic               lposc_tick,
  input  logic               mfclk_tick,
  input  logic               peri_tick,
  input  logic               lf_tick,
  output logic [NUM_ADC-1:0] adc_trig,
  output logic               osc_req
);
  logic                  tmr_en, osc_en, osc_alw, slp_src, dslp_tick, fire;
  logic [DIV_CODE_W-1:0] div_code;
  tclk_sel_e             tclk;
  logic [NUM_ADC-1:0]    trig_mask;
  logic [CNT_W-1:0]      period;
  logic [HOLD_W-1:0]     hold;

  lpt_cfg_regs #(.CNT_W(CNT_W), .NUM_ADC(NUM_ADC), .HOLD_W(HOLD_W),
                 .HOLD_DEFAULT(HOLD_DEFAULT)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(cfg_wr_en), .addr_i(cfg_addr),
    .wdata_i(cfg_wdata), .tmr_en_o(tmr_en), .osc_en_o(osc_en),
    .osc_alw_o(osc_alw), .slp_src_o(slp_src), .div_code_o(div_code),
    .tclk_o(tclk), .trig_mask_o(trig_mask), .period_o(period), .hold_o(hold));

  lpt_sleep_div #(.DIV_LOG(DIV_LOG)) u_div (
    .clk(clk), .rst_n(rst_n), .lposc_tick_i(lposc_tick),
    .mfclk_tick_i(mfclk_tick), .slp_src_i(slp_src), .div_code_i(div_code),
    .dslp_tick_o(dslp_tick));

  lpt_down_timer #(.CNT_W(CNT_W), .NUM_ADC(NUM_ADC)) u_timer (
    .clk(clk), .rst_n(rst_n), .en_i(tmr_en), .tclk_i(tclk),
    .peri_tick_i(peri_tick), .dslp_tick_i(dslp_tick), .lf_tick_i(lf_tick),
    .period_i(period), .mask_i(trig_mask), .fire_o(fire), .trig_o(adc_trig));

  lpt_osc_gate #(.HOLD_W(HOLD_W)) u_osc (
    .clk(clk), .rst_n(rst_n), .osc_en_i(osc_en), .osc_alw_i(osc_alw),
    .fire_i(fire), .lposc_tick_i(lposc_tick), .hold_i(hold),
    .osc_req_o(osc_req));

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (adc_trig == '0 && !osc_req));
endmodule

// File: tb/tb_lpt_trigger_timer.sv
module tb_lpt_trigger_timer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        lp_t = 1'b0, mf_t = 1'b0, peri_t = 1'b0, lf_t = 1'b0;
  wire  [3:0]  adc_trig;
  wire         osc_req;

  lpt_trigger_timer dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(wr_en), .cfg_addr(wr_addr),
    .cfg_wdata(wr_data), .lposc_tick(lp_t), .mfclk_tick(mf_t),
    .peri_tick(peri_t), .lf_tick(lf_t), .adc_trig(adc_trig), .osc_req(osc_req));

  int    vectors = 0;
  int    misses = 0;
  string cur_req = "R1";
  bit    done = 1'b0;

  // reference model state
  logic       m_ten, m_oen, m_alw, m_src, m_arm, s_src, s_dt, s_tt, s_fire;
  logic [2:0] m_div;
  logic [1:0] m_tclk;
  logic [3:0] m_mask, m_trig, m_scnt;
  logic [15:0] m_per, m_cnt;
  logic [7:0] m_hold, m_rem;

  function automatic logic [3:0] div_mask(input logic [2:0] code);
    case (code)
      3'd0: return 4'h0;
      3'd1: return 4'h1;
      3'd2: return 4'h3;
      3'd3: return 4'h7;
      default: return 4'hF;
    endcase
  endfunction

  function automatic logic [15:0] ctrl_word(input bit ten, input bit oen, input bit alw,
      input bit src, input logic [2:0] dv, input logic [1:0] tc, input logic [3:0] mk);
    return {mk, 2'b00, tc, 1'b0, dv, src, alw, oen, ten};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ten = 0; m_oen = 0; m_alw = 0; m_src = 0; m_div = 0; m_tclk = 0;
      m_mask = 0; m_per = 0; m_hold = 8'd4; m_scnt = 0; m_cnt = 0; m_arm = 0;
      m_trig = 0; m_rem = 0;
    end else begin
      s_src = m_src ? mf_t : lp_t;
      s_dt  = s_src && ((m_scnt & div_mask(m_div)) == div_mask(m_div));
      case (m_tclk)
        2'd0: s_tt = peri_t;
        2'd1: s_tt = s_dt;
        2'd2: s_tt = lf_t;
        default: s_tt = 1'b0;
      endcase
      s_fire = m_ten && m_arm && s_tt && (m_cnt == 0);
      m_trig = s_fire ? m_mask : 4'h0;
      if (!m_ten) begin m_cnt = 0; m_arm = 0; end
      else if (!m_arm) begin m_cnt = m_per; m_arm = 1; end
      else if (s_tt) m_cnt = (m_cnt == 0) ? m_per : m_cnt - 16'd1;
      if (!m_oen || m_alw) m_rem = 0;
      else if (s_fire) m_rem = m_hold;
      else if (lp_t && m_rem != 0) m_rem = m_rem - 8'd1;
      if (s_src) m_scnt = m_scnt + 4'd1;
      if (wr_en) begin
        case (wr_addr)
          2'd0: begin
            m_ten = wr_data[0]; m_oen = wr_data[1]; m_alw = wr_data[2];
            m_src = wr_data[3]; m_div = wr_data[6:4]; m_tclk = wr_data[9:8];
            m_mask = wr_data[15:12];
          end
          2'd1: m_per = wr_data;
          2'd2: m_hold = wr_data[7:0];
          default: ;
        endcase
      end
    end
  end

  // cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      vectors++;
      if (adc_trig !== m_trig || osc_req !== (m_oen && (m_alw || m_rem != 0))) begin
        misses++;
        $display("FAIL %s: trig=%h osc=%b expected trig=%h osc=%b", cur_req,
                 adc_trig, osc_req, m_trig, m_oen && (m_alw || m_rem != 0));
      end
    end
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_ticks(input bit lp, input bit mf, input bit pe, input bit lf);
    lp_t = lp; mf_t = mf; peri_t = pe; lf_t = lf;
  endtask

  task automatic measure_interval(input string req, input int exp);
    int n = 0;
    for (int i = 0; i < 2000 && adc_trig == 0; i++) @(negedge clk);
    do begin @(negedge clk); n++; end while (adc_trig == 0 && n < 2000);
    check(req, n, exp);
  endtask

  task automatic count_trigs(input string req, input int cycles, input int exp);
    int n = 0;
    for (int i = 0; i < cycles; i++) begin @(negedge clk); if (adc_trig != 0) n++; end
    check(req, n, exp);
  endtask

  task automatic measure_high(input string req, input int exp);
    int n = 0;
    for (int i = 0; i < 2000 && !(osc_req == 1'b0); i++) @(negedge clk);
    for (int i = 0; i < 2000 && osc_req == 1'b0; i++) @(negedge clk);
    while (osc_req == 1'b1 && n < 2000) begin n++; @(negedge clk); end
    check(req, n, exp);
  endtask

  initial begin
    #(20 * 150000);
    misses++;
    $display("FAIL %s: watchdog expired", cur_req);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    cur_req = "R1";
    check("R1", adc_trig, 0);
    check("R1", osc_req, 0);

    // R6: peripheral tick every cycle, N=3 and N=0
    cur_req = "R6";
    set_ticks(0, 0, 1, 0);
    wr(2'd1, 16'd3);
    wr(2'd0, ctrl_word(1, 0, 0, 0, 3'd0, 2'd0, 4'hF));
    measure_interval("R6", 4);
    wr(2'd0, 16'h0);
    wr(2'd1, 16'd0);
    wr(2'd0, ctrl_word(1, 0, 0, 0, 3'd0, 2'd0, 4'hF));
    measure_interval("R6", 1);

    // R7: mask selects the ADC lines
    cur_req = "R7";
    wr(2'd0, ctrl_word(1, 0, 0, 0, 3'd0, 2'd0, 4'h5));
    repeat (3) @(negedge clk);
    check("R7", adc_trig, 4'h5);

    // R4: divided sleep tick, source every cycle, divide by 4 and code 7 (16)
    cur_req = "R4";
    set_ticks(1, 0, 0, 0);
    wr(2'd0, ctrl_word(1, 0, 0, 0, 3'd2, 2'd1, 4'h1));
    measure_interval("R4", 4);
    wr(2'd0, ctrl_word(1, 0, 0, 0, 3'd7, 2'd1, 4'h1));
    measure_interval("R4", 16);

    // R3: medium-frequency source, divide by 2; then only the unselected source ticks
    cur_req = "R3";
    set_ticks(0, 1, 0, 0);
    wr(2'd0, ctrl_word(1, 0, 0, 1, 3'd1, 2'd1, 4'h2));
    measure_interval("R3", 2);
    set_ticks(1, 0, 0, 0);
    count_trigs("R3", 100, 0);

    // R5: low-frequency clock, N=2; reserved code 3
    cur_req = "R5";
    set_ticks(1, 1, 1, 1);
    wr(2'd1, 16'd2);
    wr(2'd0, ctrl_word(1, 0, 0, 0, 3'd0, 2'd2, 4'h8));
    measure_interval("R5", 3);
    wr(2'd0, ctrl_word(1, 0, 0, 0, 3'd0, 2'd3, 4'hF));
    count_trigs("R5", 100, 0);

    // R8: period change while running
    cur_req = "R8";
    set_ticks(0, 0, 1, 0);
    wr(2'd1, 16'd9);
    wr(2'd0, ctrl_word(1, 0, 0, 0, 3'd0, 2'd0, 4'hF));
    measure_interval("R8", 10);
    repeat (3) @(negedge clk);
    wr(2'd1, 16'd1);
    measure_interval("R8", 2);

    // R9: disable stops, enable restarts
    cur_req = "R9";
    wr(2'd0, ctrl_word(0, 0, 0, 0, 3'd0, 2'd0, 4'hF));
    count_trigs("R9", 60, 0);
    wr(2'd0, ctrl_word(1, 0, 0, 0, 3'd0, 2'd0, 4'hF));
    measure_interval("R9", 2);

    // R11: duty-cycled, default hold 4 then hold 2, oscillator tick every cycle
    cur_req = "R11";
    set_ticks(1, 0, 1, 0);
    wr(2'd1, 16'd9);
    wr(2'd0, ctrl_word(1, 1, 0, 0, 3'd0, 2'd0, 4'h1));
    measure_high("R11", 4);
    wr(2'd2, 16'd2);
    measure_high("R11", 2);

    // R10 and R2: always-on, write to unused address is ignored
    cur_req = "R10";
    wr(2'd0, ctrl_word(0, 1, 1, 0, 3'd0, 2'd0, 4'h0));
    check("R10", osc_req, 1);
    cur_req = "R2";
    wr(2'd3, 16'h0000);
    repeat (2) @(negedge clk);
    check("R2", osc_req, 1);

    // R12: oscillator enable cleared
    cur_req = "R12";
    wr(2'd0, ctrl_word(1, 0, 0, 0, 3'd0, 2'd0, 4'h1));
    repeat (30) @(negedge clk);
    check("R12", osc_req, 0);

    // constrained random mix
    cur_req = "R6";
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      lp_t = ($urandom % 3) == 0; mf_t = $urandom % 2;
      peri_t = ($urandom % 4) != 0; lf_t = ($urandom % 5) == 0;
      wr_en = 1'b0;
      if (($urandom % 50) == 0) begin
        wr_en = 1'b1;
        wr_addr = 2'($urandom % 4);
        case (wr_addr)
          2'd1: wr_data = 16'($urandom % 12);
          2'd2: wr_data = 16'($urandom % 6);
          default: wr_data = 16'($urandom) | 16'h0001;
        endcase
      end
    end
    @(negedge clk); wr_en = 1'b0;
    repeat (5) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule